// File: doc/BRIEF.md
# Transmit Frame Padder and FCS Appender

This stage sits in a transmit byte path between the frame source and the serialiser. It accepts frame bytes on a valid/ready stream with an end-of-frame marker. With the first byte of each frame it also takes two per-frame controls: one suppresses padding and one suppresses the frame check sequence. Data bytes pass through unchanged and with no added latency. When a frame ends, the stage can append zero bytes and then a 4-byte CRC-32 frame check sequence, which it generates itself while the source is held off.

A frame whose data is shorter than 60 bytes is extended with zeros to 60 bytes, which gives the 64-byte minimum once the check sequence is added. The pad-suppress control turns this off. Padding always brings a check sequence with it, even when the frame asked for none. A frame that is not padded gets a check sequence only if its CRC-suppress control is clear.

Top module: `txpad_fcs_appender`

## Requirements
- R1: Every accepted data byte appears on the output unchanged, in order, with none lost or repeated.
- R2: When pad-suppress is 0 and a frame carries fewer than 60 data bytes, zero-valued bytes follow its last data byte until 60 bytes have been emitted.
- R3: A padded frame always ends with a 4-byte check sequence, whatever the value of CRC-suppress.
- R4: When CRC-suppress is 1 and no padding occurs, the frame ends on its last data byte and no check sequence follows.
- R5: The check sequence is CRC-32 (reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF, result complemented) over all data and pad bytes. It is sent least significant byte first.
- R6: The pad-suppress and CRC-suppress inputs are sampled only together with a frame's first byte. Their values on later bytes and between bytes change nothing.
- R7: m_last is 1 on exactly the final byte of each output frame: the last check-sequence byte, or the last data or pad byte when no check sequence is sent.
- R8: While pad or check-sequence bytes are being emitted, s_ready is 0. A stalled pad or check-sequence byte holds its value until it is taken.
- R9: After reset the stage is idle at a frame start: m_valid follows s_valid and s_ready follows m_ready.
- R10: When pad-suppress is 1, a short frame leaves at its own length, followed by a check sequence only when CRC-suppress is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Stage accepts the input byte |
| s_data | input | 8 | Input frame byte |
| s_last | input | 1 | Input byte is the last of its frame |
| s_no_pad | input | 1 | Pad-suppress control, sampled with the first byte |
| s_no_crc | input | 1 | CRC-suppress control, sampled with the first byte |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream accepts the output byte |
| m_data | output | 8 | Output frame byte |
| m_last | output | 1 | Output byte ends the frame |

## Verification
A data byte appears on the output in the same cycle it is accepted. The first pad byte, or the first check-sequence byte when there is no padding, is presented in the cycle after the last data byte is taken. Each following generated byte is presented in the cycle after its predecessor is taken. The bench therefore treats every handshake as one step of a queue-based model. It samples at the falling edge, where the byte and last flag presented for the next rising edge are stable, and compares them with the head of the expected queue. In the same sample it checks that the source is held off whenever that head is a generated byte.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [1:0] {
    ST_DATA = 2'd0,
    ST_PAD  = 2'd1,
    ST_FCS  = 2'd2
  } tx_state_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;
  localparam int          FCS_BYTES     = 4;
  localparam int          FCS_IDX_W     = $clog2(FCS_BYTES);

  // One byte of reflected CRC-32, LSB of the byte first.
  function automatic logic [31:0] crc32_byte(input logic [31:0] c_in,
                                             input logic [7:0]  b);
    logic [31:0] c;
    c = c_in ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction

  // Byte lane of the complemented remainder, lane 0 goes first.
  function automatic logic [7:0] fcs_lane(input logic [31:0]          c,
                                          input logic [FCS_IDX_W-1:0] idx);
    logic [31:0] inv;
    inv = ~c;
    case (idx)
      2'd0:    return inv[7:0];
      2'd1:    return inv[15:8];
      2'd2:    return inv[23:16];
      default: return inv[31:24];
    endcase
  endfunction

endpackage

// File: rtl/fcs_crc_acc.sv
module fcs_crc_acc
  import fcs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic        absorb,
  input  logic [7:0]  byte_in,
  output logic [31:0] crc
);

  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       crc_q <= CRC_SEED;
    else if (restart) crc_q <= CRC_SEED;
    else if (absorb)  crc_q <= crc32_byte(crc_q, byte_in);
  end

  assign crc = crc_q;

endmodule

// File: rtl/fcs_len_track.sv
module fcs_len_track #(
  parameter int MIN_DATA = 60,
  localparam int CNT_W   = $clog2(MIN_DATA + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic clear,
  output logic is_first,
  output logic short_next,
  output logic pad_last
);

  localparam logic [CNT_W-1:0] CAP    = CNT_W'(MIN_DATA);
  localparam logic [CNT_W-1:0] CAP_M1 = CNT_W'(MIN_DATA - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (clear)                 cnt_q <= '0;
    else if (step && cnt_q != CAP)  cnt_q <= cnt_q + 1'b1;
  end

  assign is_first   = (cnt_q == '0);
  assign short_next = (cnt_q < CAP_M1);
  assign pad_last   = (cnt_q == CAP_M1);

endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
  import fcs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_fire,
  input  logic                 out_fire,
  input  logic                 s_last,
  input  logic                 s_no_pad,
  input  logic                 s_no_crc,
  input  logic                 is_first,
  input  logic                 short_next,
  input  logic                 pad_last,
  output tx_state_e            st,
  output logic [FCS_IDX_W-1:0] fcs_idx,
  output logic                 fcs_wanted
);

  localparam logic [FCS_IDX_W-1:0] LAST_IDX = FCS_IDX_W'(FCS_BYTES - 1);

  tx_state_e            st_q, st_d;
  logic [FCS_IDX_W-1:0] idx_q, idx_d;
  logic                 np_q, nc_q;
  logic                 np_eff, nc_eff, need_pad;

  // Controls are live on the first byte, latched afterwards.
  assign np_eff     = is_first ? s_no_pad : np_q;
  assign nc_eff     = is_first ? s_no_crc : nc_q;
  assign need_pad   = !np_eff && short_next;
  assign fcs_wanted = need_pad || !nc_eff;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    case (st_q)
      ST_DATA: if (in_fire && s_last)
                 st_d = need_pad ? ST_PAD : (fcs_wanted ? ST_FCS : ST_DATA);
      ST_PAD:  if (out_fire && pad_last) st_d = ST_FCS;
      ST_FCS:  if (out_fire) begin
                 if (idx_q == LAST_IDX) st_d = ST_DATA;
                 idx_d = idx_q + 1'b1;
               end
      default: st_d = ST_DATA;
    endcase
    if (st_d == ST_FCS && st_q != ST_FCS) idx_d = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_DATA;
      idx_q <= '0;
      np_q  <= 1'b0;
      nc_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      if (in_fire && is_first) begin
        np_q <= s_no_pad;
        nc_q <= s_no_crc;
      end
    end
  end

  assign st      = st_q;
  assign fcs_idx = idx_q;

  p_pad_forces_fcs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PAD && out_fire && pad_last) |=> (st_q == ST_FCS));

  p_no_fcs_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA && in_fire && s_last && !fcs_wanted) |=> (st_q == ST_DATA));

  p_ctrl_latched_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !is_first) |=> ($stable(np_q) && $stable(nc_q)));

endmodule

// File: rtl/txpad_fcs_appender.sv
module txpad_fcs_appender
  import fcs_pkg::*;
#(
  parameter int MIN_FRAME = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [7:0] s_data,
  input  logic       s_last,
  input  logic       s_no_pad,
  input  logic       s_no_crc,
  output logic       m_valid,
  input  logic       m_ready,
  output logic [7:0] m_data,
  output logic       m_last
);

  localparam int MIN_DATA = MIN_FRAME - FCS_BYTES;
  localparam logic [FCS_IDX_W-1:0] LAST_IDX = FCS_IDX_W'(FCS_BYTES - 1);

  tx_state_e            st;
  logic [FCS_IDX_W-1:0] fcs_idx;
  logic                 fcs_wanted;
  logic                 is_first, short_next, pad_last;
  logic [31:0]          crc;

  // Named events for the assertions.
  logic in_fire, out_fire, frame_end, body_beat;

  always_comb begin
    case (st)
      ST_DATA: begin
        m_valid = s_valid;
        s_ready = m_ready;
        m_data  = s_data;
        m_last  = s_last && !fcs_wanted;
      end
      ST_PAD: begin
        m_valid = 1'b1;
        s_ready = 1'b0;
        m_data  = 8'h00;
        m_last  = 1'b0;
      end
      default: begin
        m_valid = 1'b1;
        s_ready = 1'b0;
        m_data  = fcs_lane(crc, fcs_idx);
        m_last  = (fcs_idx == LAST_IDX);
      end
    endcase
  end

  assign in_fire   = s_valid && s_ready;
  assign out_fire  = m_valid && m_ready;
  assign frame_end = out_fire && m_last;
  assign body_beat = out_fire && (st != ST_FCS);

  fcs_len_track #(.MIN_DATA(MIN_DATA)) u_len (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (body_beat),
    .clear      (frame_end),
    .is_first   (is_first),
    .short_next (short_next),
    .pad_last   (pad_last)
  );

  fcs_crc_acc u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (frame_end),
    .absorb  (body_beat),
    .byte_in (m_data),
    .crc     (crc)
  );

  fcs_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_fire    (in_fire),
    .out_fire   (out_fire),
    .s_last     (s_last),
    .s_no_pad   (s_no_pad),
    .s_no_crc   (s_no_crc),
    .is_first   (is_first),
    .short_next (short_next),
    .pad_last   (pad_last),
    .st         (st),
    .fcs_idx    (fcs_idx),
    .fcs_wanted (fcs_wanted)
  );

  p_gen_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready && st != ST_DATA) |=>
      (m_valid && $stable(m_data) && $stable(m_last)));

  p_end_restarts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FCS && frame_end) |=> (st == ST_DATA && is_first));

  p_ready_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_DATA) |-> !in_fire);

endmodule

// File: tb/tb_txpad_fcs_appender.sv
`timescale 1ns/1ps
module tb_txpad_fcs_appender;

  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       s_valid, s_ready, s_last, s_no_pad, s_no_crc;
  logic [7:0] s_data;
  logic       m_valid, m_ready, m_last;
  logic [7:0] m_data;

  always #2.5 clk = ~clk;

  txpad_fcs_appender dut (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .s_no_pad(s_no_pad), .s_no_crc(s_no_crc),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int rdy_pct = 70, gap_pct = 30;
  bit done = 0;

  // Expected output model: one entry per output byte.
  logic [7:0] exp_d[$];
  bit         exp_l[$];
  int         exp_k[$];   // 0 data, 1 pad, 2 fcs
  int         exp_len[$];
  string      exp_tag[$];
  int         out_cnt = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [31:0] ref_fcs(logic [7:0] q[$]);
    logic [31:0] r = 32'hFFFFFFFF;
    foreach (q[i]) begin
      for (int b = 0; b < 8; b++) begin
        if (r[0] ^ q[i][b]) r = (r >> 1) ^ 32'hEDB88320;
        else                r = r >> 1;
      end
    end
    return ~r;
  endfunction

  // Downstream readiness
  initial begin
    m_ready = 1'b0;
    forever begin
      @(posedge clk); #1;
      m_ready = ($urandom % 100) < rdy_pct;
    end
  end

  // Watchdog and cycle count
  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      chk(0, "R8", "watchdog expired, cycles", cyc, WATCHDOG);
      finish_run();
    end
  end

  // Monitor: compare every handshake with the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (exp_k.size() > 0 && exp_k[0] != 0)
        chk(!s_ready, "R8", "s_ready while generating", s_ready, 0);
      if (m_valid && m_ready) begin
        if (exp_d.size() == 0) begin
          chk(0, "R1", "unexpected output byte", m_data, 0);
        end else begin
          string rq;
          rq = (exp_k[0] == 0) ? "R1" : (exp_k[0] == 1) ? "R2" : "R5";
          chk(m_data === exp_d[0], rq, "output byte", m_data, exp_d[0]);
          chk(m_last === exp_l[0], "R7", "last flag", m_last, exp_l[0]);
          out_cnt++;
          if (exp_l[0]) begin
            chk(out_cnt == exp_len[0], exp_tag[0], "frame length", out_cnt, exp_len[0]);
            void'(exp_len.pop_front());
            void'(exp_tag.pop_front());
            out_cnt = 0;
          end
          void'(exp_d.pop_front());
          void'(exp_l.pop_front());
          void'(exp_k.pop_front());
        end
      end
    end
  end

  task automatic send_frame(int len, bit np, bit nc, bit flip, string tag);
    logic [7:0] body[$];
    logic [31:0] f;
    bit pad, with_fcs;
    int total;
    for (int i = 0; i < len; i++) begin
      body.push_back(8'($urandom));
      exp_d.push_back(body[i]); exp_l.push_back(0); exp_k.push_back(0);
    end
    pad      = !np && (len < 60);
    with_fcs = pad || !nc;
    if (pad) begin
      for (int i = len; i < 60; i++) begin
        body.push_back(8'h00);
        exp_d.push_back(8'h00); exp_l.push_back(0); exp_k.push_back(1);
      end
    end
    total = body.size();
    if (with_fcs) begin
      f = ref_fcs(body);
      for (int k = 0; k < 4; k++) begin
        exp_d.push_back(f[8*k +: 8]); exp_l.push_back(0); exp_k.push_back(2);
      end
      total += 4;
    end
    exp_l[exp_l.size()-1] = 1;
    exp_len.push_back(total);
    exp_tag.push_back(tag);

    for (int i = 0; i < len; i++) begin
      while (($urandom % 100) < gap_pct) begin
        s_valid  = 1'b0;
        s_no_pad = 1'($urandom);
        s_no_crc = 1'($urandom);
        @(posedge clk); #1;
      end
      s_valid  = 1'b1;
      s_data   = body[i];
      s_last   = (i == len - 1);
      s_no_pad = (i == 0) ? np : (flip ? ~np : np);
      s_no_crc = (i == 0) ? nc : (flip ? ~nc : nc);
      @(negedge clk);
      while (!s_ready) @(negedge clk);
      @(posedge clk); #1;
    end
    s_valid  = 1'b0;
    s_last   = 1'b0;
    s_no_pad = flip;
    s_no_crc = flip;
  endtask

  initial begin
    rst_n = 1'b0; s_valid = 0; s_data = 0; s_last = 0; s_no_pad = 0; s_no_crc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(m_valid === 1'b0, "R9", "m_valid in reset", m_valid, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(m_valid === 1'b0, "R9", "m_valid idle after reset", m_valid, 0);
    chk(s_ready === m_ready, "R9", "s_ready follows m_ready", s_ready, m_ready);
    @(posedge clk); #1;

    send_frame(1,  0, 0, 0, "R2");
    send_frame(10, 0, 1, 0, "R3");
    send_frame(60, 0, 1, 0, "R4");
    send_frame(59, 0, 0, 0, "R2");
    send_frame(70, 0, 0, 0, "R5");
    send_frame(20, 1, 0, 0, "R10");
    send_frame(20, 1, 1, 0, "R10");
    send_frame(30, 0, 1, 1, "R6");
    send_frame(80, 0, 1, 1, "R6");
    send_frame(5,  1, 1, 1, "R6");
    for (int n = 0; n < 25; n++)
      send_frame(1 + ($urandom % 90), 1'($urandom), 1'($urandom), 1'($urandom), "R1");
    rdy_pct = 100; gap_pct = 0;
    send_frame(3,  1, 1, 0, "R4");
    send_frame(12, 0, 0, 0, "R2");
    send_frame(61, 0, 1, 0, "R4");
    rdy_pct = 20;
    send_frame(15, 0, 0, 0, "R8");

    while (exp_d.size() > 0) @(posedge clk);
    @(negedge clk);
    chk(exp_len.size() == 0, "R8", "frames outstanding", exp_len.size(), 0);
    chk(m_valid === 1'b0, "R8", "no extra output", m_valid, 0);
    finish_run();
  end

endmodule